// File: doc/BRIEF.md
# Delay-Lock Startup and Latency-Mode Controller

This block decides when a memory device's delay-lock loop may be trusted, and it tells the command pipeline which read latency to use. The loop itself is not modelled. Lock is inferred only by counting reference-clock rising edges on a fast, free-running timebase clock. The raw reference clock passes through a two-flop synchroniser and a rising-edge detector. A lock counter then tallies the detected edges. A gap timer measures how many timebase ticks have passed since the last edge.

A low level on the loop-enable pin turns the loop off. The latency output then selects the one-cycle fallback mode at once, and the lock state is discarded. With the pin high, lock is declared after a fixed number of consecutive stable reference edges. If the reference stops, or runs slower than the gap limit allows, the count is thrown away and must start again from zero. The gap limit is a parameter in timebase ticks, set by the integrator to the 30 ns minimum stall time. While the loop is enabled but not yet locked, the latency output stays on the normal 2.5-cycle setting, and the pipeline gates reads on the locked flag.

There is no data stream here, so the block has no valid/ready interface. All pins are plain control and status levels.

Top module: `dlk_startup_ctrl`

## Requirements
- R1: `lat_mode_o` encodes the latency mode as 1 for the normal 2.5-cycle mode and 0 for the one-cycle fallback. It equals `loop_en_i` in the same cycle with no register delay, and it stays 1 while the block is enabled but not yet locked.
- R2: While `loop_en_i` is 0, `locked_o` is 0 in the same cycle, the lock count is cleared, and reference edges that arrive in that time add nothing to a later count.
- R3: With `loop_en_i` at 1, `locked_o` rises on the LOCK_CYCLES-th counted reference rising edge (default 2048). It becomes visible three timebase edges after that reference edge. After LOCK_CYCLES-1 edges it is still 0.
- R4: Only rising edges of the reference count, each exactly once. Each edge reaches the counter through a two-flop synchroniser and an edge detector.
- R5: A stall is flagged when the gap timer reaches STALL_TICKS (default 12) in a cycle with no detected edge. A stall clears the lock count and drops `locked_o` at the next timebase edge. A gap of STALL_TICKS ticks that ends with an edge is not a stall.
- R6: After a stall, the count restarts from zero. The first edge after the stall counts as number 1, and LOCK_CYCLES further edges are needed in total to lock again.
- R7: A reference whose period is STALL_TICKS+1 timebase ticks or shorter locks. One with a period of STALL_TICKS+2 ticks or longer never locks.
- R8: After reset, `locked_o` is 0 and the lock count is 0.
- R9: Once locked, `locked_o` stays 1 for as long as `loop_en_i` is 1 and no stall occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timebase clock, faster than the reference |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_i | input | 1 | Raw reference clock, asynchronous to clk |
| loop_en_i | input | 1 | Loop enable pin; 0 turns the loop off |
| locked_o | output | 1 | Lock declared |
| lat_mode_o | output | 1 | 1 = normal 2.5-cycle latency, 0 = one-cycle fallback |

## Verification
The lock count is exercised with reference periods of 4, 11, 13 and 14 timebase ticks. Periods 13 and 14 sit on either side of the gap limit, so they show whether the stall compare is off by one and whether an edge that lands on the limit wins over the stall. Idle gaps of 9 and 10 extra ticks inserted after lock tell apart a tolerated slow-down and a real stall. The count after the stall then checks that it restarts from zero rather than resuming. Toggling the enable pin in the middle of a count, and sending edges while the pin is low, shows whether the pin acts at once and whether those edges are dropped.

// File: rtl/dlk_pkg.sv
package dlk_pkg;

  // Latency-mode encoding shared with the command pipeline.
  typedef enum logic {
    LAT_FALLBACK_1 = 1'b0,
    LAT_NORMAL_2P5 = 1'b1
  } lat_mode_e;

  localparam int unsigned DEF_LOCK_CYCLES = 2048;
  localparam int unsigned DEF_STALL_TICKS = 12;
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/dlk_edge_sync.sv
// Brings the raw reference into the timebase domain and emits a
// single-cycle pulse for each rising edge.
module dlk_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/dlk_stall_timer.sv
// Counts timebase ticks since the last reference edge; saturates at the
// limit. An edge in the limit cycle takes priority over the stall.
module dlk_stall_timer #(
  parameter int unsigned STALL_TICKS = 12,
  localparam int unsigned GAP_W = $clog2(STALL_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic             stall_o,
  output logic [GAP_W-1:0] gap_o
);

  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(STALL_TICKS);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              gap_q <= '0;
    else if (edge_i)         gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  assign stall_o = (gap_q == GAP_MAX) && !edge_i;
  assign gap_o   = gap_q;

endmodule

// File: rtl/dlk_lock_counter.sv
// Tallies stable reference edges; declares lock at the target count.
module dlk_lock_counter #(
  parameter int unsigned LOCK_CYCLES = 2048,
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             stall_i,
  input  logic             edge_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] LAST_BEFORE = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!enable_i || stall_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (edge_i && !lock_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_BEFORE) lock_q <= 1'b1;
    end
  end

  assign locked_o = lock_q;
  assign count_o  = cnt_q;

endmodule

// File: rtl/dlk_startup_ctrl.sv
module dlk_startup_ctrl
  import dlk_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = DEF_LOCK_CYCLES,
  parameter int unsigned STALL_TICKS = DEF_STALL_TICKS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1),
  localparam int unsigned GAP_W = $clog2(STALL_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk_i,
  input  logic loop_en_i,
  output logic locked_o,
  output logic lat_mode_o
);

  logic             ref_rise;
  logic             stall_det;
  logic             lock_q;
  logic [CNT_W-1:0] lock_cnt;
  logic [GAP_W-1:0] gap_cnt;

  dlk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ref_clk_i),
    .rise_o  (ref_rise)
  );

  dlk_stall_timer #(.STALL_TICKS(STALL_TICKS)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_i  (ref_rise),
    .stall_o (stall_det),
    .gap_o   (gap_cnt)
  );

  dlk_lock_counter #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (loop_en_i),
    .stall_i  (stall_det),
    .edge_i   (ref_rise),
    .locked_o (lock_q),
    .count_o  (lock_cnt)
  );

  // The pin acts at once on both outputs; the registered state catches up
  // on the next timebase edge.
  assign locked_o   = lock_q & loop_en_i;
  assign lat_mode_o = loop_en_i ? LAT_NORMAL_2P5 : LAT_FALLBACK_1;

endmodule

// File: rtl/dlk_startup_checker.sv
module dlk_startup_checker #(
  parameter int unsigned LOCK_CYCLES = 2048,
  parameter int unsigned STALL_TICKS = 12,
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1),
  localparam int unsigned GAP_W = $clog2(STALL_TICKS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             loop_en_i,
  input logic             locked_o,
  input logic             lat_mode_o,
  input logic             ref_rise,
  input logic             stall_det,
  input logic             lock_q,
  input logic [CNT_W-1:0] lock_cnt,
  input logic [GAP_W-1:0] gap_cnt
);

  a_r1_locked_normal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> lat_mode_o);

  a_r2_off_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en_i |-> !locked_o);

  a_r2_off_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en_i |=> (lock_cnt == '0) && !lock_q);

  a_r3_lock_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> lock_cnt == CNT_W'(LOCK_CYCLES));

  a_r4_count_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_cnt != $past(lock_cnt) && lock_cnt != '0) |-> $past(ref_rise));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_rise);

  a_r5_stall_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    stall_det |=> !lock_q && (lock_cnt == '0));

  a_r5_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= GAP_W'(STALL_TICKS));

  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && loop_en_i && !stall_det) |=> lock_q);

endmodule

bind dlk_startup_ctrl dlk_startup_checker #(
  .LOCK_CYCLES(LOCK_CYCLES),
  .STALL_TICKS(STALL_TICKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .loop_en_i  (loop_en_i),
  .locked_o   (locked_o),
  .lat_mode_o (lat_mode_o),
  .ref_rise   (ref_rise),
  .stall_det  (stall_det),
  .lock_q     (lock_q),
  .lock_cnt   (lock_cnt),
  .gap_cnt    (gap_cnt)
);

// File: tb/dlk_startup_ctrl_test.sv
`timescale 1ns/1ps
module dlk_startup_ctrl_test;

  localparam int LOCK = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic en = 1'b1;
  logic locked, lat_mode;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  dlk_startup_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_clk_i  (ref_clk),
    .loop_en_i  (en),
    .locked_o   (locked),
    .lat_mode_o (lat_mode)
  );

  // Rows: {high ticks, low ticks, expect lock}; period = high + low.
  localparam logic [23:0] VEC [4] = '{
    {8'd2, 8'd2, 8'd1},   // fast reference
    {8'd6, 8'd5, 8'd1},   // period 11
    {8'd6, 8'd7, 8'd1},   // period 13 = limit + 1, edge wins
    {8'd7, 8'd7, 8'd0}    // period 14, stalls every cycle
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // Starts at a negedge; ends at a negedge.
  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      ref_clk = 1'b1;
      repeat (hi) @(negedge clk);
      ref_clk = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic relock_clear();
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 locked after reset", locked, 1'b0);
    chk("R1 normal mode while unlocked", lat_mode, 1'b1);

    // Table walk: R3 exact count, R7 period limits.
    for (int v = 0; v < 4; v++) begin
      relock_clear();
      pulses(LOCK - 1, int'(VEC[v][23:16]), int'(VEC[v][15:8]));
      chk("R3 not locked one edge short", locked, 1'b0);
      chk("R1 mode held normal before lock", lat_mode, 1'b1);
      pulses(1, int'(VEC[v][23:16]), int'(VEC[v][15:8]));
      chk("R7 lock by reference period", locked, VEC[v][0]);
    end

    // Lock with a fast reference, then probe gap handling.
    relock_clear();
    pulses(LOCK, 2, 2);
    chk("R3 locked at target", locked, 1'b1);
    repeat (9) @(negedge clk);          // gap 12 ends with an edge
    pulses(1, 2, 2);
    chk("R5 gap at limit with edge keeps lock", locked, 1'b1);
    chk("R9 lock held", locked, 1'b1);
    repeat (10) @(negedge clk);         // gap reaches 12 with no edge
    pulses(1, 2, 2);
    chk("R5 stall drops lock", locked, 1'b0);
    pulses(LOCK - 2, 2, 2);
    chk("R6 count restarted, one short", locked, 1'b0);
    pulses(1, 2, 2);
    chk("R6 relock after full count", locked, 1'b1);

    // Enable pin behaviour.
    en = 1'b0;
    #1;
    chk("R2 locked drops at once", locked, 1'b0);
    chk("R1 fallback mode at once", lat_mode, 1'b0);
    @(negedge clk);
    pulses(500, 2, 2);
    chk("R2 no lock while off", locked, 1'b0);
    en = 1'b1;
    #1;
    chk("R1 normal mode on enable", lat_mode, 1'b1);
    chk("R2 not locked right after enable", locked, 1'b0);
    @(negedge clk);
    pulses(1000, 2, 2);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    pulses(LOCK - 1, 2, 2);
    chk("R2 off mid-count discards edges", locked, 1'b0);
    pulses(1, 2, 2);
    chk("R4 each rising edge counted once", locked, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule